// File: doc/BRIEF.md
# DC-Mode Intra Prediction Sample Generator

This block builds one square luma prediction block in DC mode for block sizes 4, 8, 16 and 32. A client hands it the full set of neighbouring reference samples in one beat. That set holds 4*nt+1 bytes, packed with byte k at bits [8k+7:8k]. Index 2nt is the top-left corner, the top neighbour of column x sits at index 2nt+1+x, and the left neighbour of row y sits at index 2nt-1-y. The block sets each left and top neighbour list apart at load time. It then averages the two lists into a single DC level.

For blocks smaller than 32x32, the samples on the top edge and the left edge are blended with their neighbour to soften the block border. A 32x32 block comes out as a flat fill of the DC level. Rows leave the block in order from row 0, one row per output beat, under a valid/ready handshake. A flag marks the final row. A size outside the four legal values produces no output and raises an error flag.

Top module: `dcpred_dc`

## Requirements
- R1: While the active-low synchronous reset `rst_n` is low, and in the cycle after it, `out_valid` is 0, `ref_ready` is 1 and `size_err` is 0.
- R2: A block is accepted on a clock edge with `ref_valid` and `ref_ready` both high. `ref_ready` stays low from that edge until the edge on which the last row is taken. The first row is valid two cycles after the accepting edge. While `ref_ready` is low, `ref_valid` has no effect.
- R3: The DC level equals the sum of the nt top samples (indices 2nt+1..3nt), plus the nt left samples (indices nt..2nt-1), plus nt, shifted right by log2(nt)+1.
- R4: For nt below 32, the sample at row 0, column 0 is (ref[2nt-1] + ref[2nt+1] + 2*DC + 2) >> 2.
- R5: For nt below 32, row 0, column x>=1 is (ref[2nt+1+x] + 3*DC + 2) >> 2, clamped to 255.
- R6: For nt below 32, column 0, row y>=1 is (ref[2nt-1-y] + 3*DC + 2) >> 2, clamped to 255.
- R7: Samples with both row and column at least 1 equal DC. For nt of 32, all 1024 samples equal DC.
- R8: A load with `ref_nt` not in {4, 8, 16, 32} is consumed. It produces no output beat, leaves `ref_ready` high and sets `size_err` from the next cycle. The next legal load clears `size_err`.
- R9: Each beat carries one row, with column x at bits [8x+7:8x] of `out_row` and bytes at columns nt and above equal to zero. Rows go out in order 0 to nt-1. `out_last` is high only on row nt-1. While `out_valid` is high and `out_ready` is low, the row and flag hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_valid | input | 1 | Reference set and size offered |
| ref_ready | output | 1 | Block idle and able to take a reference set |
| ref_nt | input | 6 | Block size nt |
| ref_data | input | 1032 | 129 reference bytes, byte k at bits [8k+7:8k] |
| out_valid | output | 1 | A predicted row is offered |
| out_ready | input | 1 | Consumer takes the offered row |
| out_row | output | 256 | Predicted row, column x at bits [8x+7:8x] |
| out_last | output | 1 | Offered row is row nt-1 |
| size_err | output | 1 | Last load carried an illegal size |

## Verification
The checker watches several properties on every cycle:
- `ref_ready` and `out_valid` never overlap, and a held row stays stable under back-pressure.
- `out_last` falls exactly on beat nt-1, counted from the accepted size.
- The bytes above the active width are zero, and a 32x32 row is one repeated byte.
- An illegal load raises the error flag without starting output.

The numerical content of each row can only be shown by the bench's scenarios:
- the DC average, the corner blend and the top and left edge blends;
- the saturation case with all-255 references;
- the two-cycle start latency.
These are checked against a behavioural model over ramps, random data, extreme values and a load held pending while a block drains.

// File: rtl/dcpred_pkg.sv
package dcpred_pkg;

    // Control phase of the predictor
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_CALC = 2'd1,
        PH_EMIT = 2'd2
    } phase_e;

endpackage

// File: rtl/dcpred_size_dec.sv
// Recognises a legal block size and returns its base-2 logarithm.
module dcpred_size_dec #(
    parameter int MIN_NT = 4,
    parameter int MAX_NT = 32,
    parameter int NT_W   = $clog2(MAX_NT) + 1,
    parameter int LG_W   = $clog2($clog2(MAX_NT) + 1)
) (
    input  logic [NT_W-1:0] nt,
    output logic            legal,
    output logic [LG_W-1:0] lg
);
    localparam int LO = $clog2(MIN_NT);
    localparam int HI = $clog2(MAX_NT);

    logic [HI:LO] hit;

    generate
        for (genvar k = LO; k <= HI; k++) begin : g_size
            assign hit[k] = (nt == NT_W'(1 << k));
        end
    endgenerate

    always_comb begin
        legal = |hit;
        lg    = '0;
        for (int k = LO; k <= HI; k++) begin
            if (hit[k]) begin
                lg = LG_W'(k);
            end
        end
    end
endmodule

// File: rtl/dcpred_align.sv
// Pulls the top and left neighbour lists out of the packed reference set,
// zeroing entries beyond the block size.
module dcpred_align #(
    parameter int MAX_NT = 32,
    parameter int SW     = 8,
    parameter int NT_W   = $clog2(MAX_NT) + 1
) (
    input  logic [4*MAX_NT:0][SW-1:0]  refs,
    input  logic [NT_W-1:0]            nt,
    output logic [MAX_NT-1:0][SW-1:0]  top,
    output logic [MAX_NT-1:0][SW-1:0]  left
);
    localparam int REF_N = 4 * MAX_NT + 1;
    localparam int IDX_W = $clog2(REF_N);

    always_comb begin
        for (int i = 0; i < MAX_NT; i++) begin
            top[i]  = '0;
            left[i] = '0;
            if (i < int'(nt)) begin
                if (2 * int'(nt) + 1 + i < REF_N) begin
                    top[i] = refs[IDX_W'(2 * int'(nt) + 1 + i)];
                end
                if (2 * int'(nt) - 1 - i >= 0) begin
                    left[i] = refs[IDX_W'(2 * int'(nt) - 1 - i)];
                end
            end
        end
    end
endmodule

// File: rtl/dcpred_dc_calc.sv
// Averages both neighbour lists (with rounding term nt) into the DC level.
module dcpred_dc_calc #(
    parameter int MAX_NT = 32,
    parameter int SW     = 8,
    parameter int NT_W   = $clog2(MAX_NT) + 1,
    parameter int LG_W   = $clog2($clog2(MAX_NT) + 1)
) (
    input  logic [MAX_NT-1:0][SW-1:0] top,
    input  logic [MAX_NT-1:0][SW-1:0] left,
    input  logic [NT_W-1:0]           nt,
    input  logic [LG_W-1:0]           lg,
    output logic [SW-1:0]             dc
);
    localparam int ACC_W = $clog2(2 * MAX_NT * ((1 << SW) - 1) + MAX_NT + 1);

    logic [ACC_W-1:0] acc;

    always_comb begin
        acc = ACC_W'(nt);
        for (int i = 0; i < MAX_NT; i++) begin
            acc = acc + ACC_W'(top[i]) + ACC_W'(left[i]);
        end
        dc = SW'(acc >> (lg + 1'b1));
    end
endmodule

// File: rtl/dcpred_row_gen.sv
// Forms one output row from the DC level and the edge neighbours.
module dcpred_row_gen #(
    parameter int MAX_NT = 32,
    parameter int SW     = 8,
    parameter int NT_W   = $clog2(MAX_NT) + 1,
    parameter int ROW_W  = $clog2(MAX_NT)
) (
    input  logic [MAX_NT-1:0][SW-1:0] top,
    input  logic [MAX_NT-1:0][SW-1:0] left,
    input  logic [SW-1:0]             dc,
    input  logic [ROW_W-1:0]          row,
    input  logic [NT_W-1:0]           nt,
    input  logic                      flat,
    output logic [MAX_NT-1:0][SW-1:0] px
);
    localparam int SUM_W = SW + 3;
    localparam logic [SUM_W-1:0] MAXV = SUM_W'((1 << SW) - 1);

    function automatic logic [SW-1:0] clip(input logic [SUM_W-1:0] v);
        logic [SUM_W-1:0] s;
        s = v >> 2;
        return (s > MAXV) ? SW'(MAXV) : SW'(s);
    endfunction

    logic [SUM_W-1:0] three_dc;
    logic [SW-1:0]    corner;
    logic [SW-1:0]    side_px;

    always_comb begin
        three_dc = SUM_W'(dc) + SUM_W'(dc) + SUM_W'(dc) + SUM_W'(2);
        corner   = clip(SUM_W'(top[0]) + SUM_W'(left[0]) +
                        SUM_W'(dc) + SUM_W'(dc) + SUM_W'(2));
        side_px  = clip(SUM_W'(left[row]) + three_dc);
        for (int x = 0; x < MAX_NT; x++) begin
            if (x >= int'(nt)) begin
                px[x] = '0;
            end else if (flat) begin
                px[x] = dc;
            end else if (row == '0) begin
                px[x] = (x == 0) ? corner : clip(SUM_W'(top[x]) + three_dc);
            end else if (x == 0) begin
                px[x] = side_px;
            end else begin
                px[x] = dc;
            end
        end
    end
endmodule

// File: rtl/dcpred_dc.sv
// DC-mode intra predictor: load reference set, compute DC, stream rows.
module dcpred_dc #(
    parameter int MAX_NT  = 32,
    parameter int MIN_NT  = 4,
    parameter int FLAT_NT = 32,
    parameter int SW      = 8,
    parameter int NT_W    = $clog2(MAX_NT) + 1,
    parameter int REF_N   = 4 * MAX_NT + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ref_valid,
    output logic                   ref_ready,
    input  logic [NT_W-1:0]        ref_nt,
    input  logic [REF_N*SW-1:0]    ref_data,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [MAX_NT*SW-1:0]   out_row,
    output logic                   out_last,
    output logic                   size_err
);
    import dcpred_pkg::*;

    localparam int LG_W  = $clog2($clog2(MAX_NT) + 1);
    localparam int ROW_W = $clog2(MAX_NT);

    typedef struct packed {
        phase_e                    ph;
        logic [NT_W-1:0]           nt;
        logic [LG_W-1:0]           lg;
        logic [ROW_W-1:0]          row;
        logic [SW-1:0]             dc;
        logic [MAX_NT-1:0][SW-1:0] top;
        logic [MAX_NT-1:0][SW-1:0] left;
        logic                      err;
    } ctx_t;

    ctx_t cur_q, cur_d;

    logic [REF_N-1:0][SW-1:0]  refs_w;
    logic                      legal_w;
    logic [LG_W-1:0]           lg_w;
    logic [MAX_NT-1:0][SW-1:0] top_w, left_w, px_w;
    logic [SW-1:0]             dc_w;
    logic                      flat_w;
    logic                      last_row_w;

    assign refs_w = ref_data;

    dcpred_size_dec #(
        .MIN_NT(MIN_NT), .MAX_NT(MAX_NT), .NT_W(NT_W), .LG_W(LG_W)
    ) u_size (
        .nt(ref_nt), .legal(legal_w), .lg(lg_w)
    );

    dcpred_align #(
        .MAX_NT(MAX_NT), .SW(SW), .NT_W(NT_W)
    ) u_align (
        .refs(refs_w), .nt(ref_nt), .top(top_w), .left(left_w)
    );

    dcpred_dc_calc #(
        .MAX_NT(MAX_NT), .SW(SW), .NT_W(NT_W), .LG_W(LG_W)
    ) u_dc (
        .top(cur_q.top), .left(cur_q.left), .nt(cur_q.nt), .lg(cur_q.lg), .dc(dc_w)
    );

    assign flat_w = (int'(cur_q.nt) >= FLAT_NT);

    dcpred_row_gen #(
        .MAX_NT(MAX_NT), .SW(SW), .NT_W(NT_W), .ROW_W(ROW_W)
    ) u_row (
        .top(cur_q.top), .left(cur_q.left), .dc(cur_q.dc), .row(cur_q.row),
        .nt(cur_q.nt), .flat(flat_w), .px(px_w)
    );

    assign last_row_w = ({1'b0, cur_q.row} == (cur_q.nt - 1'b1));

    always_comb begin
        cur_d = cur_q;
        unique case (cur_q.ph)
            PH_IDLE: begin
                if (ref_valid) begin
                    if (legal_w) begin
                        cur_d.ph   = PH_CALC;
                        cur_d.nt   = ref_nt;
                        cur_d.lg   = lg_w;
                        cur_d.top  = top_w;
                        cur_d.left = left_w;
                        cur_d.row  = '0;
                        cur_d.err  = 1'b0;
                    end else begin
                        cur_d.err  = 1'b1;
                    end
                end
            end
            PH_CALC: begin
                cur_d.dc = dc_w;
                cur_d.ph = PH_EMIT;
            end
            PH_EMIT: begin
                if (out_ready) begin
                    if (last_row_w) begin
                        cur_d.ph = PH_IDLE;
                    end else begin
                        cur_d.row = cur_q.row + 1'b1;
                    end
                end
            end
            default: cur_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= cur_d;
        end
    end

    assign ref_ready = (cur_q.ph == PH_IDLE);
    assign out_valid = (cur_q.ph == PH_EMIT);
    assign out_last  = out_valid && last_row_w;
    assign out_row   = px_w;
    assign size_err  = cur_q.err;
endmodule

// File: rtl/dcpred_dc_chk.sv
// Protocol and format properties for dcpred_dc.
module dcpred_dc_chk #(
    parameter int MAX_NT  = 32,
    parameter int MIN_NT  = 4,
    parameter int FLAT_NT = 32,
    parameter int SW      = 8,
    parameter int NT_W    = $clog2(MAX_NT) + 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ref_valid,
    input logic                 ref_ready,
    input logic [NT_W-1:0]      ref_nt,
    input logic                 out_valid,
    input logic                 out_ready,
    input logic [MAX_NT*SW-1:0] out_row,
    input logic                 out_last,
    input logic                 size_err
);
    logic            legal_in;
    logic [NT_W-1:0] blk_nt_q;
    logic [NT_W-1:0] beat_q;

    assign legal_in = ($countones(ref_nt) == 1) &&
                      (int'(ref_nt) >= MIN_NT) && (int'(ref_nt) <= MAX_NT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_nt_q <= NT_W'(MIN_NT);
            beat_q   <= '0;
        end else if (ref_valid && ref_ready && legal_in) begin
            blk_nt_q <= ref_nt;
            beat_q   <= '0;
        end else if (out_valid && out_ready) begin
            beat_q   <= beat_q + 1'b1;
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && ref_ready && !size_err));

    assert_busy_after_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_valid && ref_ready && legal_in) |=> !ref_ready);

    assert_no_overlap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !ref_ready);

    assert_illegal_size_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_valid && ref_ready && !legal_in) |=> (size_err && !out_valid && ref_ready));

    assert_hold_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_row) && $stable(out_last)));

    assert_last_beat_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_last == (beat_q == blk_nt_q - 1'b1)));

    assert_upper_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_row >> (int'(blk_nt_q) * SW)) == '0));

    assert_flat_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && int'(blk_nt_q) == FLAT_NT) |-> (out_row == {MAX_NT{out_row[SW-1:0]}}));
endmodule

bind dcpred_dc dcpred_dc_chk #(
    .MAX_NT(MAX_NT), .MIN_NT(MIN_NT), .FLAT_NT(FLAT_NT), .SW(SW), .NT_W(NT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_ready(ref_ready),
    .ref_nt(ref_nt), .out_valid(out_valid), .out_ready(out_ready),
    .out_row(out_row), .out_last(out_last), .size_err(size_err)
);

// File: tb/dcpred_dc_test.sv
`timescale 1ns/1ps
module dcpred_dc_test;
    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ref_valid = 1'b0;
    logic          ref_ready;
    logic [5:0]    ref_nt = 6'd4;
    logic [1031:0] ref_data = '0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [255:0]  out_row;
    logic          out_last;
    logic          size_err;

    always #4 clk = ~clk;

    dcpred_dc uut (
        .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_ready(ref_ready),
        .ref_nt(ref_nt), .ref_data(ref_data), .out_valid(out_valid),
        .out_ready(out_ready), .out_row(out_row), .out_last(out_last),
        .size_err(size_err)
    );

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    logic [255:0] exp_rows[$];
    bit           exp_last[$];
    bit           exp_err = 0;
    int           since = 99;
    bit           stall = 0;
    bit           last_acc = 0;

    function automatic int rb(input logic [1031:0] d, input int k);
        return int'(d[8*k +: 8]);
    endfunction

    // R3: behavioural DC average
    function automatic int dc_of(input logic [1031:0] d, input int n);
        int s = n;
        for (int i = 0; i < n; i++) s += rb(d, n + i) + rb(d, 2*n + 1 + i);
        return s >> ($clog2(n) + 1);
    endfunction

    function automatic int sat(input int v);
        return (v > 255) ? 255 : v;
    endfunction

    function automatic logic [255:0] model_row(input logic [1031:0] d, input int n, input int y);
        logic [255:0] r = '0;
        int dc = dc_of(d, n);
        for (int x = 0; x < n; x++) begin
            int v;
            if (n == 32)              v = dc;
            else if (y == 0 && x == 0) v = sat((rb(d, 2*n-1) + rb(d, 2*n+1) + 2*dc + 2) >> 2);
            else if (y == 0)          v = sat((rb(d, 2*n+1+x) + 3*dc + 2) >> 2);
            else if (x == 0)          v = sat((rb(d, 2*n-1-y) + 3*dc + 2) >> 2);
            else                      v = dc;
            r[8*x +: 8] = 8'(v);
        end
        return r;
    endfunction

    function automatic string tag_of(input int y, input int x, input int n);
        if (x >= n)         return "R9";
        if (n == 32)        return "R7";
        if (y == 0 && x == 0) return "R4";
        if (y == 0)         return "R5";
        if (x == 0)         return "R6";
        return "R7";
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [255:0] got, input logic [255:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    int row_idx = 0;
    int cur_n = 4;

    // One clock: apply the model for the coming edge, then compare after it.
    task automatic step();
        bit acc_in, acc_out;
        out_ready = stall ? (($urandom % 3) != 0) : 1'b1;
        acc_in  = rst_n && ref_valid && ref_ready;
        acc_out = rst_n && out_valid && out_ready;
        last_acc = acc_in;
        if (!rst_n) begin
            exp_rows.delete(); exp_last.delete();
            exp_err = 0; since = 99;
        end else begin
            if (acc_out && exp_rows.size() > 0) begin
                void'(exp_rows.pop_front()); void'(exp_last.pop_front());
                row_idx++;
            end
            if (acc_in) begin
                int n = int'(ref_nt);
                if (n == 4 || n == 8 || n == 16 || n == 32) begin
                    for (int y = 0; y < n; y++) begin
                        exp_rows.push_back(model_row(ref_data, n, y));
                        exp_last.push_back(y == n - 1);
                    end
                    exp_err = 0; since = 0; row_idx = 0; cur_n = n;
                end else begin
                    exp_err = 1;
                end
            end
            if (since < 99) since++;
        end
        @(negedge clk);
        begin
            bit ev = (exp_rows.size() > 0) && (since >= 2);
            bit er = (exp_rows.size() == 0);
            chk(out_valid == ev, "R2", "out_valid", 256'(out_valid), 256'(ev));
            chk(ref_ready == er, "R2", "ref_ready", 256'(ref_ready), 256'(er));
            chk(size_err == exp_err, "R8", "size_err", 256'(size_err), 256'(exp_err));
            if (ev && out_valid) begin
                logic [255:0] e = exp_rows[0];
                string t = "R9";
                for (int x = 31; x >= 0; x--)
                    if (out_row[8*x +: 8] !== e[8*x +: 8]) t = tag_of(row_idx, x, cur_n);
                chk(out_row === e, t, $sformatf("row %0d nt %0d", row_idx, cur_n), out_row, e);
                chk(out_last == exp_last[0], "R9", "out_last", 256'(out_last), 256'(exp_last[0]));
            end
        end
    endtask

    task automatic load(input int n);
        ref_nt = 6'(n);
        ref_valid = 1'b1;
        do step(); while (!last_acc);
        ref_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_rows.size() > 0) step();
        step();
    endtask

    initial begin
        repeat (3) step();
        // R1: reset state observed with rst_n low
        chk(!out_valid && ref_ready && !size_err, "R1", "reset outputs",
            {ref_ready, out_valid, size_err}, 256'h4);
        rst_n = 1'b1;
        step();
        chk(!out_valid && ref_ready && !size_err, "R1", "after reset",
            {ref_ready, out_valid, size_err}, 256'h4);

        // R3 R4 R5 R6: nt=4 random neighbours, no stall
        for (int k = 0; k < 129; k++) ref_data[8*k +: 8] = 8'($urandom);
        load(4); drain();

        // R5 R6: nt=8 ramp with back-pressure, R9 hold
        stall = 1;
        for (int k = 0; k < 129; k++) ref_data[8*k +: 8] = 8'(k * 3);
        load(8); drain();

        // R5 R6 clamp: nt=16 all 255
        ref_data = '1;
        load(16); drain();

        // R7: nt=32 flat fill, random data
        for (int k = 0; k < 129; k++) ref_data[8*k +: 8] = 8'($urandom);
        load(32); drain();

        // R8: illegal sizes, then a legal zero block clears the flag
        stall = 0;
        load(12); step();
        load(0);  step();
        load(63); step();
        load(2);  step();
        ref_data = '0;
        load(4); drain();

        // R2: load held while busy is ignored until the block drains
        stall = 1;
        for (int k = 0; k < 129; k++) ref_data[8*k +: 8] = 8'($urandom);
        load(8);
        ref_nt = 6'd16; ref_valid = 1'b1;
        for (int k = 0; k < 129; k++) ref_data[8*k +: 8] = 8'($urandom);
        do step(); while (!last_acc);
        ref_valid = 1'b0;
        drain();

        // More random blocks of each size
        for (int t = 0; t < 8; t++) begin
            for (int k = 0; k < 129; k++) ref_data[8*k +: 8] = 8'($urandom);
            load(4 << (t % 4)); drain();
        end

        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            compared++;
            mismatched++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule